// File: doc/BRIEF.md
# Rotating-dispatch interrupt controller

This block gathers a vector of interrupt status lines from on-chip sources and gates them with an enable mask that software owns. A source counts as pending only when both its status line and its mask bit are high. The block tells the CPU that something is pending through one registered summary request. When the CPU's handler asks for work with a one-cycle dispatch pulse, the block names exactly one pending source.

The search for that source has no fixed priority. It starts at a saved scan pointer and walks upward through the indices, wrapping at the source count. After a successful pick, the pointer rests one place past the chosen index, so the next search starts after the source that was just served.

The source count is 32 or 64. An optional cascade window, which is a contiguous and inclusive range of indices, is reported in a separate external number space counted from the start of the window. Software reads the status lines or the mask through a small read port. It can load the whole mask, set one mask bit or clear one mask bit.

Top module: `irqc_rotating_dispatch`

## Requirements
- R1: A synchronous active-high reset sets the mask to all zeros and the scan pointer to 0, and drives `irq_req` and `disp_valid` low.
- R2: `irq_req` equals the OR of (`src_status` AND mask) as sampled one clock earlier. A source whose mask bit is 0 never raises it.
- R3: A `disp_req` pulse sampled at one clock edge produces exactly one `disp_valid` pulse, one cycle wide, after that same edge.
- R4: The search tests indices in increasing order, starting at the pointer and wrapping. After a hit, the pointer equals the chosen index plus one. A source that is still pending therefore does not win again until the other pending sources above it have been served.
- R5: When nothing is pending, the `disp_valid` pulse comes with `disp_hit`=0 and the pointer keeps its value.
- R6: With cascading enabled (default window 24..27 inclusive), a hit inside the window gives `disp_ext`=1 and `disp_num` = index minus 24. A hit outside the window gives `disp_ext`=0 and `disp_num` = index.
- R7: `mask_set_en` sets only bit `mask_set_idx`, and `mask_clr_en` clears only bit `mask_clr_idx`, and no other bit changes. If both name the same bit in one cycle, the bit ends cleared.
- R8: `mask_wr_en` loads `mask_wr_data` into the whole mask and takes precedence over any set or clear in the same cycle.
- R9: `rd_data` shows `src_status` when `rd_sel`=0 and the mask when `rd_sel`=1, with no clock delay.
- R10: A dispatch that is sampled at the same edge as a mask update uses the mask as it stood before that edge.
- R11: The pointer wraps from the last index to 0, so index 0 is found after the top index has been served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_status | input | NUM_SRC | Raw interrupt status lines |
| rd_sel | input | 1 | Read select: 0 status, 1 mask |
| rd_data | output | NUM_SRC | Read data |
| mask_wr_en | input | 1 | Load whole mask |
| mask_wr_data | input | NUM_SRC | Mask load value |
| mask_set_en | input | 1 | Set one mask bit |
| mask_set_idx | input | IDXW | Bit to set |
| mask_clr_en | input | 1 | Clear one mask bit |
| mask_clr_idx | input | IDXW | Bit to clear |
| irq_req | output | 1 | Registered summary request to the CPU |
| disp_req | input | 1 | One-cycle dispatch request |
| disp_valid | output | 1 | Dispatch answer strobe |
| disp_hit | output | 1 | A pending source was found |
| disp_ext | output | 1 | Chosen index lies in the cascade window |
| disp_idx | output | IDXW | Chosen raw index |
| disp_num | output | IDXW | Internal or external number |

## Verification
A dispatch and a mask update can fall on the same clock edge. A handler may clear the bit of the source it is about to serve while its next dispatch request is in flight. The bench provokes this by pulsing `disp_req` together with `mask_clr_en` on the only pending source. It judges the result by the answer carrying that source (R10), by the mask reading back with the bit cleared, and by `irq_req` staying high for one more cycle before it drops.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic {
        RD_STATUS = 1'b0,
        RD_MASK   = 1'b1
    } rd_sel_e;

    typedef struct packed {
        logic hit;
        logic ext;
    } disp_flags_t;

    function automatic int idx_bits(input int n);
        return (n > 32) ? 6 : 5;
    endfunction

endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int N    = 32,
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [N-1:0]    wr_data,
    input  logic            set_en,
    input  logic [IDXW-1:0] set_idx,
    input  logic            clr_en,
    input  logic [IDXW-1:0] clr_idx,
    output logic [N-1:0]    mask_q
);
    logic [N-1:0] set_vec;
    logic [N-1:0] clr_vec;
    logic [N-1:0] mask_d;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (set_en) set_vec[set_idx] = 1'b1;
        if (clr_en) clr_vec[clr_idx] = 1'b1;
        if (wr_en)
            mask_d = wr_data;
        else
            mask_d = (mask_q | set_vec) & ~clr_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end
endmodule

// File: rtl/irqc_rr_pick.sv
module irqc_rr_pick #(
    parameter int N    = 32,
    parameter int IDXW = 5
) (
    input  logic [N-1:0]    pend,
    input  logic [IDXW-1:0] ptr,
    output logic            found,
    output logic [IDXW-1:0] sel
);
    logic [N-1:0]    rot;
    logic [IDXW-1:0] off;

    always_comb begin
        rot   = N'({pend, pend} >> ptr);
        found = 1'b0;
        off   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (rot[i]) begin
                found = 1'b1;
                off   = IDXW'(i);
            end
        end
        sel = ptr + off;
    end
endmodule

// File: rtl/irqc_map.sv
module irqc_map #(
    parameter int IDXW       = 5,
    parameter bit CASCADE_EN = 1'b1,
    parameter int EXT_START  = 24,
    parameter int EXT_END    = 27
) (
    input  logic [IDXW-1:0] idx,
    output logic            ext,
    output logic [IDXW-1:0] num
);
    localparam logic [IDXW-1:0] WIN_LO = IDXW'(EXT_START);
    localparam logic [IDXW-1:0] WIN_HI = IDXW'(EXT_END);

    generate
        if (CASCADE_EN) begin : g_cascade
            always_comb begin
                ext = (idx >= WIN_LO) && (idx <= WIN_HI);
                num = ext ? (idx - WIN_LO) : idx;
            end
        end else begin : g_flat
            always_comb begin
                ext = 1'b0;
                num = idx;
            end
        end
    endgenerate
endmodule

// File: rtl/irqc_rotating_dispatch.sv
module irqc_rotating_dispatch
    import irqc_pkg::*;
#(
    parameter int NUM_SRC    = 32,
    parameter bit CASCADE_EN = 1'b1,
    parameter int EXT_START  = 24,
    parameter int EXT_END    = 27,
    localparam int IDXW      = idx_bits(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_status,
    input  logic               rd_sel,
    output logic [NUM_SRC-1:0] rd_data,
    input  logic               mask_wr_en,
    input  logic [NUM_SRC-1:0] mask_wr_data,
    input  logic               mask_set_en,
    input  logic [IDXW-1:0]    mask_set_idx,
    input  logic               mask_clr_en,
    input  logic [IDXW-1:0]    mask_clr_idx,
    output logic               irq_req,
    input  logic               disp_req,
    output logic               disp_valid,
    output logic               disp_hit,
    output logic               disp_ext,
    output logic [IDXW-1:0]    disp_idx,
    output logic [IDXW-1:0]    disp_num
);
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend;
    logic [IDXW-1:0]    scan_ptr;
    logic               pick_found;
    logic [IDXW-1:0]    pick_sel;
    logic               map_ext;
    logic [IDXW-1:0]    map_num;
    disp_flags_t        flags_q;
    logic               irq_q;
    logic               valid_q;
    logic [IDXW-1:0]    idx_q;
    logic [IDXW-1:0]    num_q;

    irqc_mask_reg #(.N(NUM_SRC), .IDXW(IDXW)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mask_wr_en),
        .wr_data (mask_wr_data),
        .set_en  (mask_set_en),
        .set_idx (mask_set_idx),
        .clr_en  (mask_clr_en),
        .clr_idx (mask_clr_idx),
        .mask_q  (mask_q)
    );

    assign pend = src_status & mask_q;

    irqc_rr_pick #(.N(NUM_SRC), .IDXW(IDXW)) u_pick (
        .pend  (pend),
        .ptr   (scan_ptr),
        .found (pick_found),
        .sel   (pick_sel)
    );

    irqc_map #(
        .IDXW       (IDXW),
        .CASCADE_EN (CASCADE_EN),
        .EXT_START  (EXT_START),
        .EXT_END    (EXT_END)
    ) u_map (
        .idx (pick_sel),
        .ext (map_ext),
        .num (map_num)
    );

    always_comb begin
        case (rd_sel_e'(rd_sel))
            RD_MASK: rd_data = mask_q;
            default: rd_data = src_status;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q    <= 1'b0;
            valid_q  <= 1'b0;
            flags_q  <= '0;
            idx_q    <= '0;
            num_q    <= '0;
            scan_ptr <= '0;
        end else begin
            irq_q   <= |pend;
            valid_q <= disp_req;
            if (disp_req) begin
                flags_q.hit <= pick_found;
                flags_q.ext <= pick_found & map_ext;
                idx_q       <= pick_found ? pick_sel : '0;
                num_q       <= pick_found ? map_num : '0;
                if (pick_found) scan_ptr <= pick_sel + 1'b1;
            end
        end
    end

    assign irq_req    = irq_q;
    assign disp_valid = valid_q;
    assign disp_hit   = flags_q.hit;
    assign disp_ext   = flags_q.ext;
    assign disp_idx   = idx_q;
    assign disp_num   = num_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int N         = 32,
    parameter int IDXW      = 5,
    parameter int EXT_START = 24,
    parameter int EXT_END   = 27
) (
    input logic            clk,
    input logic            rst,
    input logic [N-1:0]    src_status,
    input logic [N-1:0]    mask_q,
    input logic            mask_wr_en,
    input logic [N-1:0]    mask_wr_data,
    input logic            irq_req,
    input logic            disp_req,
    input logic            disp_valid,
    input logic            disp_hit,
    input logic            disp_ext,
    input logic [IDXW-1:0] disp_idx,
    input logic [IDXW-1:0] disp_num,
    input logic [IDXW-1:0] scan_ptr
);
    localparam logic [IDXW-1:0] LO = IDXW'(EXT_START);
    localparam logic [IDXW-1:0] HI = IDXW'(EXT_END);

    logic [N-1:0] pend_d;
    always_ff @(posedge clk) pend_d <= src_status & mask_q;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (mask_q == '0 && scan_ptr == '0 && !irq_req && !disp_valid));

    a_r2_irq_summary: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_req == (|pend_d)));

    a_r3_valid_after_req: assert property (@(posedge clk) disable iff (rst)
        disp_req |=> disp_valid);

    a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !disp_req |=> !disp_valid);

    a_r4_ptr_past_hit: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_hit) |-> (scan_ptr == IDXW'(disp_idx + 1'b1)));

    a_r4_hit_was_pending: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_hit && !$past(rst)) |-> pend_d[disp_idx]);

    a_r5_ptr_hold_on_miss: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_hit) |-> $stable(scan_ptr));

    a_r6_ext_in_window: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ext) |->
            (disp_idx >= LO && disp_idx <= HI && disp_num == disp_idx - LO));

    a_r8_write_loads: assert property (@(posedge clk) disable iff (rst)
        mask_wr_en |=> (mask_q == $past(mask_wr_data)));
endmodule

bind irqc_rotating_dispatch irqc_checker #(
    .N         (NUM_SRC),
    .IDXW      (IDXW),
    .EXT_START (EXT_START),
    .EXT_END   (EXT_END)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .src_status   (src_status),
    .mask_q       (mask_q),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_data (mask_wr_data),
    .irq_req      (irq_req),
    .disp_req     (disp_req),
    .disp_valid   (disp_valid),
    .disp_hit     (disp_hit),
    .disp_ext     (disp_ext),
    .disp_idx     (disp_idx),
    .disp_num     (disp_num),
    .scan_ptr     (scan_ptr)
);

// File: tb/irqc_rotating_dispatch_tb.sv
module irqc_rotating_dispatch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src_status = '0;
    logic         rd_sel = 1'b0;
    logic [N-1:0] rd_data;
    logic         mask_wr_en = 1'b0;
    logic [N-1:0] mask_wr_data = '0;
    logic         mask_set_en = 1'b0;
    logic [W-1:0] mask_set_idx = '0;
    logic         mask_clr_en = 1'b0;
    logic [W-1:0] mask_clr_idx = '0;
    logic         irq_req;
    logic         disp_req = 1'b0;
    logic         disp_valid, disp_hit, disp_ext;
    logic [W-1:0] disp_idx, disp_num;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irqc_rotating_dispatch u_dut (
        .clk(clk), .rst(rst), .src_status(src_status),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .mask_set_en(mask_set_en), .mask_set_idx(mask_set_idx),
        .mask_clr_en(mask_clr_en), .mask_clr_idx(mask_clr_idx),
        .irq_req(irq_req), .disp_req(disp_req),
        .disp_valid(disp_valid), .disp_hit(disp_hit), .disp_ext(disp_ext),
        .disp_idx(disp_idx), .disp_num(disp_num)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] read_mask();
        return rd_data;
    endfunction

    task automatic get_mask(output logic [N-1:0] m);
        rd_sel = 1'b1;
        #1;
        m = rd_data;
        rd_sel = 1'b0;
    endtask

    task automatic write_mask(input logic [N-1:0] v);
        @(negedge clk);
        mask_wr_en = 1'b1; mask_wr_data = v;
        @(negedge clk);
        mask_wr_en = 1'b0;
    endtask

    task automatic set_clr(input logic se, input int si, input logic ce, input int ci);
        @(negedge clk);
        mask_set_en = se; mask_set_idx = W'(si);
        mask_clr_en = ce; mask_clr_idx = W'(ci);
        @(negedge clk);
        mask_set_en = 1'b0; mask_clr_en = 1'b0;
    endtask

    task automatic dispatch(input string req, input logic exp_hit, input int exp_idx,
                            input logic exp_ext, input int exp_num);
        @(negedge clk);
        disp_req = 1'b1;
        @(negedge clk);
        disp_req = 1'b0;
        check(disp_valid === 1'b1, "R3", disp_valid, 1);
        check(disp_hit === exp_hit, req, disp_hit, exp_hit);
        if (exp_hit) begin
            check(disp_idx === W'(exp_idx), req, disp_idx, exp_idx);
            check(disp_ext === exp_ext, "R6", disp_ext, exp_ext);
            check(disp_num === W'(exp_num), "R6", disp_num, exp_num);
        end
        @(negedge clk);
        check(disp_valid === 1'b0, "R3", disp_valid, 0);
    endtask

    task automatic t_reset();
        logic [N-1:0] m;
        get_mask(m);
        check(m === '0, "R1", m, 0);
        check(irq_req === 1'b0, "R1", irq_req, 0);
        check(disp_valid === 1'b0, "R1", disp_valid, 0);
    endtask

    task automatic t_read_and_gate();
        @(negedge clk);
        src_status = 32'hA5A5_0F0F;
        #1;
        check(rd_data === 32'hA5A5_0F0F, "R9", rd_data, 32'hA5A5_0F0F);
        repeat (2) @(negedge clk);
        check(irq_req === 1'b0, "R2", irq_req, 0);
        src_status = '0;
    endtask

    task automatic t_mask_ops();
        logic [N-1:0] m;
        write_mask(32'h0F0F_0000);
        get_mask(m);
        check(m === 32'h0F0F_0000, "R8", m, 32'h0F0F_0000);
        set_clr(1'b1, 3, 1'b0, 0);
        get_mask(m);
        check(m === 32'h0F0F_0008, "R7", m, 32'h0F0F_0008);
        set_clr(1'b0, 0, 1'b1, 16);
        get_mask(m);
        check(m === 32'h0F0E_0008, "R7", m, 32'h0F0E_0008);
        set_clr(1'b1, 5, 1'b1, 5);
        get_mask(m);
        check(m === 32'h0F0E_0008, "R7", m, 32'h0F0E_0008);
        set_clr(1'b1, 6, 1'b1, 17);
        get_mask(m);
        check(m === 32'h0F0C_0048, "R7", m, 32'h0F0C_0048);
        @(negedge clk);
        mask_wr_en = 1'b1; mask_wr_data = 32'h1234_5678;
        mask_set_en = 1'b1; mask_set_idx = 5'd0;
        mask_clr_en = 1'b1; mask_clr_idx = 5'd3;
        @(negedge clk);
        mask_wr_en = 1'b0; mask_set_en = 1'b0; mask_clr_en = 1'b0;
        get_mask(m);
        check(m === 32'h1234_5678, "R8", m, 32'h1234_5678);
    endtask

    task automatic t_irq_timing();
        write_mask('1);
        @(negedge clk);
        src_status = 32'h0000_0100;
        #1;
        check(irq_req === 1'b0, "R2", irq_req, 0);
        @(negedge clk);
        check(irq_req === 1'b1, "R2", irq_req, 1);
        src_status = '0;
        @(negedge clk);
        check(irq_req === 1'b0, "R2", irq_req, 0);
    endtask

    task automatic t_rotate();
        @(negedge clk);
        src_status = (32'd1 << 3) | (32'd1 << 10);
        dispatch("R1", 1'b1, 3, 1'b0, 3);
        dispatch("R4", 1'b1, 10, 1'b0, 10);
        dispatch("R4", 1'b1, 3, 1'b0, 3);
        src_status = '0;
        dispatch("R5", 1'b0, 0, 1'b0, 0);
        src_status = (32'd1 << 2) | (32'd1 << 6);
        dispatch("R5", 1'b1, 6, 1'b0, 6);
    endtask

    task automatic t_wrap();
        src_status = (32'd1 << 31) | 32'd1;
        dispatch("R11", 1'b1, 31, 1'b0, 31);
        dispatch("R11", 1'b1, 0, 1'b0, 0);
    endtask

    task automatic t_cascade();
        src_status = 32'd1 << 24;
        dispatch("R6", 1'b1, 24, 1'b1, 0);
        src_status = 32'd1 << 27;
        dispatch("R6", 1'b1, 27, 1'b1, 3);
        src_status = 32'd1 << 23;
        dispatch("R6", 1'b1, 23, 1'b0, 23);
        src_status = 32'd1 << 28;
        dispatch("R6", 1'b1, 28, 1'b0, 28);
    endtask

    task automatic t_same_cycle();
        logic [N-1:0] m;
        write_mask(32'd1 << 9);
        src_status = 32'd1 << 9;
        @(negedge clk);
        disp_req = 1'b1;
        mask_clr_en = 1'b1; mask_clr_idx = 5'd9;
        @(negedge clk);
        disp_req = 1'b0; mask_clr_en = 1'b0;
        check(disp_valid === 1'b1 && disp_hit === 1'b1, "R10", disp_hit, 1);
        check(disp_idx === 5'd9, "R10", disp_idx, 9);
        check(irq_req === 1'b1, "R10", irq_req, 1);
        get_mask(m);
        check(m === '0, "R10", m, 0);
        @(negedge clk);
        check(irq_req === 1'b0, "R10", irq_req, 0);
        src_status = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_and_gate();
        t_mask_ops();
        t_irq_timing();
        t_rotate();
        t_wrap();
        t_cascade();
        t_same_cycle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule